// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block sits between a set of peripheral interrupt lines and a CPU. It takes a parameterised number of maskable sources plus two sources that cannot be masked: a non-maskable interrupt (NMI) and an address-break request. Each maskable source has its own enable bit and a one-bit level. Level 1 marks a priority source and level 0 a plain one. Two CPU mask bits decide which requests may be taken. The primary mask is `mask_i_o` and the secondary mask is `mask_ui_o`. With the primary mask clear, every enabled request is eligible. With only the primary mask set, priority-level sources still pass. With both masks set, only the NMI and address break pass.

Among the eligible requests, one winner is chosen by a fixed order. The choice is handed to the CPU only on a cycle where the instruction-boundary strobe is high. The hand-off is a one-cycle `take_o` pulse with a registered vector number. On that hand-off the block sets both mask bits. Software changes the mask bits through separate write enables.

Requests are level-sensitive. A request stays pending until its source drops it, usually after the handler has acknowledged it.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A maskable source whose enable bit is 0 is never accepted, whatever its request and level.
- R2: A level-1 source (`src_lvl_i` bit = 1) is eligible when the primary mask is 0, or when the primary mask is 1 and the secondary mask is 0.
- R3: A level-0 source is eligible only when the primary mask is 0.
- R4: When both mask bits are 1, only the NMI and the address break can be accepted. Every maskable request stays pending.
- R5: The winner is chosen in this order: NMI, then address break, then level-1 sources, then level-0 sources. Within a level, the lower source index wins. The vector numbers are 0 for NMI, 1 for address break, and k+2 for maskable source k.
- R6: Acceptance happens only at a clock edge where `insn_done_i` is 1. `take_o` and `vec_o` show the result in the cycle after that edge.
- R7: `take_o` is high for exactly one cycle per acceptance. `vec_o` is registered and keeps the last accepted vector until the next acceptance.
- R8: On an acceptance, both `mask_i_o` and `mask_ui_o` become 1 in the same cycle that `take_o` is high.
- R9: A write through `i_we_i` changes only the primary mask. In particular, clearing the primary mask leaves the secondary mask unchanged.
- R10: If an acceptance and a software mask write occur at the same edge, the acceptance wins and both mask bits become 1.
- R11: After reset, both mask bits are 1, `take_o` is 0 and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | NUM_SRC | Level request of each maskable source |
| src_en_i | input | NUM_SRC | Enable bit of each maskable source |
| src_lvl_i | input | NUM_SRC | Level of each source, 1 = priority |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| brk_req_i | input | 1 | Address-break request |
| insn_done_i | input | 1 | Instruction-boundary strobe |
| i_we_i | input | 1 | Write enable for the primary mask |
| i_wdata_i | input | 1 | Write data for the primary mask |
| ui_we_i | input | 1 | Write enable for the secondary mask |
| ui_wdata_i | input | 1 | Write data for the secondary mask |
| mask_i_o | output | 1 | Primary mask bit |
| mask_ui_o | output | 1 | Secondary mask bit |
| take_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | VEC_W | Vector number of the last accepted request |

## Verification
The bound checker watches every cycle for several conditions. An acceptance must follow a boundary strobe, and it must leave both masks set. A maskable vector must never be accepted while both masks were set. A level-0 source must never be accepted while the primary mask was set. An NMI present at a boundary must always win with vector 0. A primary-only write must keep the secondary mask. The ordering inside the maskable groups, the effect of the enable bits, and the precedence of acceptance over a same-cycle write can only be shown by the directed scenarios. The same holds for the held vector and the length of the pulse. Each of these scenarios sets up a known mask state and known competing requests.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int VEC_NMI  = 0;
   localparam int VEC_BRK  = 1;
   localparam int VEC_BASE = 2;

   function automatic int vec_width(input int nsrc);
      return (nsrc + VEC_BASE > 2) ? $clog2(nsrc + VEC_BASE) : 1;
   endfunction

   function automatic int idx_width(input int nsrc);
      return (nsrc > 1) ? $clog2(nsrc) : 1;
   endfunction
endpackage

// File: rtl/irq_elig.sv
module irq_elig #(
   parameter int NUM_SRC = 8
) (
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] lvl_i,
   input  logic               mask_i_i,
   input  logic               mask_ui_i,
   output logic [NUM_SRC-1:0] hi_ok_o,
   output logic [NUM_SRC-1:0] lo_ok_o
);
   logic hi_gate;
   logic lo_gate;

   assign hi_gate = !mask_i_i || !mask_ui_i;
   assign lo_gate = !mask_i_i;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      logic live;
      assign live       = req_i[k] && en_i[k];
      assign hi_ok_o[k] = live &&  lvl_i[k] && hi_gate;
      assign lo_ok_o[k] = live && !lvl_i[k] && lo_gate;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      found_o = |req_i;
      idx_o   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) idx_o = IDX_W'(k);
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic i_we_i,
   input  logic i_wdata_i,
   input  logic ui_we_i,
   input  logic ui_wdata_i,
   output logic i_q_o,
   output logic ui_q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         i_q_o  <= 1'b1;
         ui_q_o <= 1'b1;
      end else if (set_i) begin
         i_q_o  <= 1'b1;
         ui_q_o <= 1'b1;
      end else begin
         if (i_we_i)  i_q_o  <= i_wdata_i;
         if (ui_we_i) ui_q_o <= ui_wdata_i;
      end
   end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC = 8,
   localparam int VEC_W  = vec_width(NUM_SRC),
   localparam int IDX_W  = idx_width(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_req_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic [NUM_SRC-1:0] src_lvl_i,
   input  logic               nmi_req_i,
   input  logic               brk_req_i,
   input  logic               insn_done_i,
   input  logic               i_we_i,
   input  logic               i_wdata_i,
   input  logic               ui_we_i,
   input  logic               ui_wdata_i,
   output logic               mask_i_o,
   output logic               mask_ui_o,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_o
);
   if (NUM_SRC < 1 || NUM_SRC > 256) begin : g_bad_nsrc
      $error("prio_irq_arbiter: NUM_SRC out of range");
   end

   logic [NUM_SRC-1:0] hi_ok;
   logic [NUM_SRC-1:0] lo_ok;
   logic               hi_found;
   logic               lo_found;
   logic [IDX_W-1:0]   hi_idx;
   logic [IDX_W-1:0]   lo_idx;
   logic               any_ok;
   logic               accept;
   logic [VEC_W-1:0]   win_vec;

   irq_elig #(.NUM_SRC(NUM_SRC)) elig_i (
      .req_i     (src_req_i),
      .en_i      (src_en_i),
      .lvl_i     (src_lvl_i),
      .mask_i_i  (mask_i_o),
      .mask_ui_i (mask_ui_o),
      .hi_ok_o   (hi_ok),
      .lo_ok_o   (lo_ok)
   );

   irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) pick_hi_i (
      .req_i   (hi_ok),
      .found_o (hi_found),
      .idx_o   (hi_idx)
   );

   irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) pick_lo_i (
      .req_i   (lo_ok),
      .found_o (lo_found),
      .idx_o   (lo_idx)
   );

   always_comb begin
      win_vec = '0;
      if (nmi_req_i)      win_vec = VEC_W'(VEC_NMI);
      else if (brk_req_i) win_vec = VEC_W'(VEC_BRK);
      else if (hi_found)  win_vec = VEC_W'(hi_idx) + VEC_W'(VEC_BASE);
      else if (lo_found)  win_vec = VEC_W'(lo_idx) + VEC_W'(VEC_BASE);
   end

   assign any_ok = nmi_req_i || brk_req_i || hi_found || lo_found;
   assign accept = insn_done_i && any_ok;

   irq_mask_reg mask_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (accept),
      .i_we_i     (i_we_i),
      .i_wdata_i  (i_wdata_i),
      .ui_we_i    (ui_we_i),
      .ui_wdata_i (ui_wdata_i),
      .i_q_o      (mask_i_o),
      .ui_q_o     (mask_ui_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         take_o <= 1'b0;
         vec_o  <= '0;
      end else begin
         take_o <= accept;
         if (accept) vec_o <= win_vec;
      end
   end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC = 8,
   localparam int VEC_W  = vec_width(NUM_SRC)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] src_lvl_i,
   input logic               nmi_req_i,
   input logic               insn_done_i,
   input logic               i_we_i,
   input logic               ui_we_i,
   input logic               mask_i_o,
   input logic               mask_ui_o,
   input logic               take_o,
   input logic [VEC_W-1:0]   vec_o
);
   logic [NUM_SRC-1:0] lvl_q;
   logic [VEC_W-1:0]   src_of_vec;
   logic               won_lvl;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= '0;
      else         lvl_q <= src_lvl_i;
   end

   assign src_of_vec = vec_o - VEC_W'(VEC_BASE);
   always_comb begin
      won_lvl = 1'b0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (src_of_vec == VEC_W'(k)) won_lvl = lvl_q[k];
      end
   end

   // R6
   take_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> $past(insn_done_i));

   // R8
   masks_set_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (mask_i_o && mask_ui_o));

   // R4
   full_mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && $past(mask_i_o) && $past(mask_ui_o)) |-> (vec_o < VEC_W'(VEC_BASE)));

   // R3
   plain_needs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && $past(mask_i_o) && (vec_o >= VEC_W'(VEC_BASE))) |-> won_lvl);

   // R5
   nmi_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(insn_done_i) && $past(nmi_req_i)) |-> (take_o && vec_o == VEC_W'(VEC_NMI)));

   // R9
   ui_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!take_o && $past(i_we_i) && !$past(ui_we_i)) |-> (mask_ui_o == $past(mask_ui_o)));
endmodule

bind prio_irq_arbiter irq_arb_chk #(.NUM_SRC(NUM_SRC)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .src_lvl_i   (src_lvl_i),
   .nmi_req_i   (nmi_req_i),
   .insn_done_i (insn_done_i),
   .i_we_i      (i_we_i),
   .ui_we_i     (ui_we_i),
   .mask_i_o    (mask_i_o),
   .mask_ui_o   (mask_ui_o),
   .take_o      (take_o),
   .vec_o       (vec_o)
);

// File: tb/prio_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_irq_arbiter_tb_top;
   localparam int NS = 8;
   localparam int VW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] req = '0, en = '1, lvl = '0;
   logic          nmi = 1'b0, brk = 1'b0, done = 1'b0;
   logic          iwe = 1'b0, iwd = 1'b0, uwe = 1'b0, uwd = 1'b0;
   logic          mi, mui, take;
   logic [VW-1:0] vec;
   int            checks = 0, fails = 0;
   bit            finished = 1'b0;

   always #4 clk = ~clk;

   prio_irq_arbiter #(.NUM_SRC(NS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .src_en_i(en), .src_lvl_i(lvl),
      .nmi_req_i(nmi), .brk_req_i(brk), .insn_done_i(done),
      .i_we_i(iwe), .i_wdata_i(iwd), .ui_we_i(uwe), .ui_wdata_i(uwd),
      .mask_i_o(mi), .mask_ui_o(mui), .take_o(take), .vec_o(vec)
   );

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   task automatic clr();
      req = '0; lvl = '0; en = '1; nmi = 1'b0; brk = 1'b0;
   endtask

   task automatic set_mask(input logic i_v, input logic ui_v);
      @(negedge clk); iwe = 1'b1; iwd = i_v; uwe = 1'b1; uwd = ui_v;
      @(negedge clk); iwe = 1'b0; uwe = 1'b0;
   endtask

   task automatic boundary();
      @(negedge clk); done = 1'b1;
      @(negedge clk); done = 1'b0;
   endtask

   task automatic t_reset();
      chk(mi == 1'b1 && mui == 1'b1, "R11 masks", {mi, mui}, 3);
      chk(take == 1'b0, "R11 take", take, 0);
      chk(vec == '0, "R11 vec", vec, 0);
   endtask

   task automatic t_full_mask();
      clr(); lvl[3] = 1'b1; req[3] = 1'b1;
      boundary();
      chk(take == 1'b0, "R4 maskable blocked", take, 0);
      nmi = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 0, "R4 nmi passes", vec, 0);
      clr();
   endtask

   task automatic t_write_i_only();
      @(negedge clk); iwe = 1'b1; iwd = 1'b0;
      @(negedge clk); iwe = 1'b0;
      chk(mi == 1'b0 && mui == 1'b1, "R9 clear I keeps UI", {mi, mui}, 1);
   endtask

   task automatic t_level_order();
      clr(); req[3] = 1'b1; req[5] = 1'b1; lvl[5] = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 7, "R5 level1 over level0", vec, 7);
      chk(mi == 1'b1 && mui == 1'b1, "R8 masks set", {mi, mui}, 3);
      @(negedge clk);
      chk(take == 1'b0, "R7 single pulse", take, 1'b0);
      chk(vec == 7, "R7 vec held", vec, 7);
      clr();
   endtask

   task automatic t_half_mask();
      set_mask(1'b1, 1'b0);
      clr(); req[1] = 1'b1;
      boundary();
      chk(take == 1'b0, "R3 level0 blocked by I", take, 0);
      req[6] = 1'b1; lvl[6] = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 8, "R2 level1 with I=1 UI=0", vec, 8);
      clr();
   endtask

   task automatic t_enable();
      set_mask(1'b0, 1'b0);
      clr(); req[2] = 1'b1; lvl[2] = 1'b1; en[2] = 1'b0;
      boundary();
      chk(take == 1'b0, "R1 disabled source", take, 0);
      chk(mi == 1'b0, "R1 mask untouched", mi, 0);
      en[2] = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 4, "R1 enabled source", vec, 4);
      clr();
   endtask

   task automatic t_groups();
      set_mask(1'b0, 1'b0);
      clr(); req[2] = 1'b1; req[4] = 1'b1; lvl[2] = 1'b1; lvl[4] = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 4, "R5 lower index wins", vec, 4);
      set_mask(1'b0, 1'b0);
      clr(); brk = 1'b1; req[0] = 1'b1; lvl[0] = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 1, "R5 break over source", vec, 1);
      set_mask(1'b0, 1'b0);
      clr(); brk = 1'b1; nmi = 1'b1;
      boundary();
      chk(take == 1'b1 && vec == 0, "R5 nmi over break", vec, 0);
      clr();
   endtask

   task automatic t_strobe();
      set_mask(1'b0, 1'b0);
      clr(); req[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(take == 1'b0, "R6 no strobe no take", take, 0);
      end
      boundary();
      chk(take == 1'b1 && vec == 2, "R6 take after strobe", vec, 2);
      clr();
   endtask

   task automatic t_precedence();
      set_mask(1'b0, 1'b0);
      clr();
      @(negedge clk);
      req[1] = 1'b1; lvl[1] = 1'b1; done = 1'b1;
      iwe = 1'b1; iwd = 1'b0; uwe = 1'b1; uwd = 1'b0;
      @(negedge clk);
      done = 1'b0; iwe = 1'b0; uwe = 1'b0;
      chk(take == 1'b1 && vec == 3, "R10 accept taken", vec, 3);
      chk(mi == 1'b1 && mui == 1'b1, "R10 accept beats write", {mi, mui}, 3);
      clr();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_mask();
      t_write_i_only();
      t_level_order();
      t_half_mask();
      t_enable();
      t_groups();
      t_strobe();
      t_precedence();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule